// File: doc/BRIEF.md
# Latched Program Counter Unit

This unit holds the 21-bit byte address of the next instruction fetch in a small core that has separate program and data paths. The core's register-file bus can see the counter through three byte-wide windows. The low counter byte is read and written directly. The middle and upper counter bytes are never touched by the bus. They are loaded from two holding latches, and the bus can write and read those latches.

A write to the low-byte window performs a computed jump. In that single cycle, both holding latches and the written byte load into the counter together. A read of the low-byte window copies the current middle and upper counter bytes into the latches. Software can then add an offset and write the result back.

The unit also handles the following:
- reset to address zero;
- loading of the two interrupt vectors;
- sequential advance by one 16-bit instruction word.

On the fetch side, it presents the counter as the fetch address. It passes the program-memory word through only when that address lies inside the implemented memory. Above that point, it returns zero, which the decoder treats as a no-op.

Top module: `pc_unit`

## Requirements
- R1: While rst_ni is low, the counter and both holding latches are zero, with no clock needed. After release, the bus reads 0x00 from windows 1 and 2.
- R2: When adv_i is high and no higher-priority load is active, the counter increases by 2 at the next rising edge. The result wraps modulo 2^21, so 0x1FFFFE is followed by 0x000000.
- R3: bus_sel_i selects the bus window: 0 = low counter byte, 1 = middle latch, 2 = upper latch, 3 = unused.
  - A write to window 1 stores all 8 data bits.
  - A write to window 2 stores data bits 4:0. Reads of window 2 return bits 7:5 as zero.
  - Window 3 reads 0x00, and writes to it change nothing.
  - Latch writes never change the counter.
- R4: A write to window 0 loads the counter at the next edge with {upper latch, middle latch, written byte with bit 0 cleared}. The latch values used are the ones held before that edge.
- R5: A read of window 0 returns counter bits 7:0 in the same cycle. At the next edge, it copies counter bits 15:8 into the middle latch and bits 20:16 into the upper latch.
- R6: irq_hi_i loads 0x000008 at the next edge, and irq_lo_i loads 0x000018. If both are high, 0x000008 is loaded.
- R7: The load priority is: reset, then either interrupt, then a window-0 write, then sequential advance. A window-0 write that is overridden by an interrupt is lost.
- R8: When the counter is at or above MEM_BYTES, instr_o is 0x0000 and fetch_ok_o is low. Otherwise, instr_o equals mem_rdata_i and fetch_ok_o is high. fetch_addr_o always equals the counter.
- R9: Counter bit 0 is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adv_i | input | 1 | Advance by one instruction word |
| irq_hi_i | input | 1 | High-priority interrupt vector load |
| irq_lo_i | input | 1 | Low-priority interrupt vector load |
| bus_sel_i | input | 2 | Bus window select |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data for the selected window |
| pc_o | output | 21 | Current counter value |
| fetch_addr_o | output | 21 | Program-memory fetch address |
| mem_rdata_i | input | 16 | Word returned by program memory |
| instr_o | output | 16 | Range-gated instruction word |
| fetch_ok_o | output | 1 | Fetch address lies inside implemented memory |

## Verification
Bus read data, instr_o and fetch_ok_o are combinational from the present counter and inputs, so they are due in the same cycle as the stimulus. Counter loads and latch updates are due exactly one rising edge later. Reset takes effect at once.

The bench drives inputs just after a falling edge and compares all outputs 2 ns later. It compares against a behavioural model holding the state before the coming edge, and only then advances the model. Every comparison therefore sees same-cycle results immediately and registered results on the following cycle.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int PC_W  = 21;
  localparam int BYTE_W = 8;
  localparam int UP_W  = PC_W - 2 * BYTE_W;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    WIN_LO   = 2'd0,
    WIN_MID  = 2'd1,
    WIN_UP   = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  localparam logic [PC_W-1:0] VEC_RST = 21'h000000;
  localparam logic [PC_W-1:0] VEC_HI  = 21'h000008;
  localparam logic [PC_W-1:0] VEC_LO  = 21'h000018;
  localparam logic [PC_W-1:0] STEP    = 21'd2;
endpackage

// File: rtl/pc_latches.sv
module pc_latches
  import pc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mid_i,
  input  logic              wr_up_i,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [BYTE_W-1:0] lat_mid_o,
  output logic [UP_W-1:0]   lat_up_o
);
  logic [BYTE_W-1:0] mid_q;
  logic [UP_W-1:0]   up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q <= '0;
      up_q  <= '0;
    end else if (cap_i) begin
      mid_q <= pc_i[2*BYTE_W-1:BYTE_W];
      up_q  <= pc_i[PC_W-1:2*BYTE_W];
    end else begin
      if (wr_mid_i) mid_q <= wdata_i;
      if (wr_up_i)  up_q  <= wdata_i[UP_W-1:0];
    end
  end

  assign lat_mid_o = mid_q;
  assign lat_up_o  = up_q;

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (mid_q == $past(pc_i[2*BYTE_W-1:BYTE_W])) &&
              (up_q == $past(pc_i[PC_W-1:2*BYTE_W])));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !wr_mid_i && !wr_up_i) |=> $stable(mid_q) && $stable(up_q));
endmodule

// File: rtl/pc_core.sv
module pc_core
  import pc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              irq_hi_i,
  input  logic              irq_lo_i,
  input  logic              wr_lo_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] lat_mid_i,
  input  logic [UP_W-1:0]   lat_up_i,
  output logic [PC_W-1:0]   pc_o
);
  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (irq_hi_i)      pc_d = VEC_HI;
    else if (irq_lo_i) pc_d = VEC_LO;
    else if (wr_lo_i)  pc_d = {lat_up_i, lat_mid_i, wdata_i[BYTE_W-1:1], 1'b0};
    else if (adv_i)    pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= VEC_RST;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !irq_hi_i && !irq_lo_i && !wr_lo_i) |=> pc_q == $past(pc_q) + STEP);
  p_vec_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hi_i |=> pc_q == VEC_HI);
  p_vec_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_i && !irq_hi_i) |=> pc_q == VEC_LO);
  p_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !irq_hi_i && !irq_lo_i) |=>
      pc_q[PC_W-1:BYTE_W] == $past({lat_up_i, lat_mid_i}));
  p_even_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[0] == 1'b0);
endmodule

// File: rtl/pc_fetch_gate.sv
module pc_fetch_gate
  import pc_pkg::*;
#(
  parameter int MEM_BYTES = 8192
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [PC_W-1:0]   fetch_addr_o,
  output logic [WORD_W-1:0] instr_o,
  output logic              ok_o
);
  localparam longint SPACE = longint'(1) << PC_W;

  logic in_range;

  generate
    if (MEM_BYTES >= SPACE) begin : g_full
      assign in_range = 1'b1;
    end else begin : g_part
      localparam logic [PC_W:0] LIMIT = (PC_W+1)'(MEM_BYTES);
      assign in_range = {1'b0, pc_i} < LIMIT;
    end
  endgenerate

  assign fetch_addr_o = pc_i;
  assign ok_o         = in_range;
  assign instr_o      = in_range ? mem_rdata_i : '0;
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
#(
  parameter int MEM_BYTES = 8192
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  input  logic        irq_hi_i,
  input  logic        irq_lo_i,
  input  logic [1:0]  bus_sel_i,
  input  logic        bus_we_i,
  input  logic        bus_re_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic [20:0] pc_o,
  output logic [20:0] fetch_addr_o,
  input  logic [15:0] mem_rdata_i,
  output logic [15:0] instr_o,
  output logic        fetch_ok_o
);
  win_e              win;
  logic              wr_lo, wr_mid, wr_up, cap;
  logic [PC_W-1:0]   pc;
  logic [BYTE_W-1:0] lat_mid;
  logic [UP_W-1:0]   lat_up;

  assign win    = win_e'(bus_sel_i);
  assign wr_lo  = bus_we_i && (win == WIN_LO);
  assign wr_mid = bus_we_i && (win == WIN_MID);
  assign wr_up  = bus_we_i && (win == WIN_UP);
  assign cap    = bus_re_i && (win == WIN_LO);

  pc_latches u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_mid_i  (wr_mid),
    .wr_up_i   (wr_up),
    .cap_i     (cap),
    .wdata_i   (bus_wdata_i),
    .pc_i      (pc),
    .lat_mid_o (lat_mid),
    .lat_up_o  (lat_up)
  );

  pc_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv_i),
    .irq_hi_i  (irq_hi_i),
    .irq_lo_i  (irq_lo_i),
    .wr_lo_i   (wr_lo),
    .wdata_i   (bus_wdata_i),
    .lat_mid_i (lat_mid),
    .lat_up_i  (lat_up),
    .pc_o      (pc)
  );

  pc_fetch_gate #(.MEM_BYTES(MEM_BYTES)) u_gate (
    .pc_i         (pc),
    .mem_rdata_i  (mem_rdata_i),
    .fetch_addr_o (fetch_addr_o),
    .instr_o      (instr_o),
    .ok_o         (fetch_ok_o)
  );

  always_comb begin
    unique case (win)
      WIN_LO:  bus_rdata_o = pc[BYTE_W-1:0];
      WIN_MID: bus_rdata_o = lat_mid;
      WIN_UP:  bus_rdata_o = {{(BYTE_W-UP_W){1'b0}}, lat_up};
      default: bus_rdata_o = '0;
    endcase
  end

  assign pc_o = pc;

  p_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_ok_o |-> (instr_o == 16'h0000) && (fetch_addr_o == pc_o));
  p_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i == 2'd2) |-> bus_rdata_o[7:5] == 3'b000);
endmodule

// File: tb/sim_pc_unit.sv
module sim_pc_unit;
  localparam int MEM = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 0, irq_h = 0, irq_l = 0, we = 0, re = 0;
  logic [1:0]  sel = 0;
  logic [7:0]  wd = 0;
  logic [7:0]  rd;
  logic [20:0] pc, faddr;
  logic [15:0] mem = 0, instr;
  logic        ok;

  int n_cmp = 0, n_bad = 0;
  int m_pc = 0, m_mid = 0, m_up = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_unit #(.MEM_BYTES(MEM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .irq_hi_i(irq_h), .irq_lo_i(irq_l),
    .bus_sel_i(sel), .bus_we_i(we), .bus_re_i(re), .bus_wdata_i(wd),
    .bus_rdata_o(rd), .pc_o(pc), .fetch_addr_o(faddr), .mem_rdata_i(mem),
    .instr_o(instr), .fetch_ok_o(ok)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive, compare same-cycle outputs, then step the model over the edge
  task automatic cyc(string req, bit a, bit ih, bit il, bit w, bit r, int s, int d);
    int exp_rd, old_pc, new_pc;
    @(negedge clk);
    adv = a; irq_h = ih; irq_l = il; we = w; re = r;
    sel = 2'(s); wd = 8'(d); mem = 16'($urandom);
    #2;
    chk(req, "pc", int'(pc), m_pc);
    chk(req, "fetch_addr", int'(faddr), m_pc);
    chk("R9", "pc bit0", int'(pc[0]), 0);
    case (s)
      0: exp_rd = m_pc & 'hFF;
      1: exp_rd = m_mid;
      2: exp_rd = m_up;
      default: exp_rd = 0;
    endcase
    chk(req, "rdata", int'(rd), exp_rd);
    chk("R8", "instr", int'(instr), (m_pc < MEM) ? int'(mem) : 0);
    chk("R8", "fetch_ok", int'(ok), (m_pc < MEM) ? 1 : 0);
    old_pc = m_pc;
    if (ih)                new_pc = 'h8;
    else if (il)           new_pc = 'h18;
    else if (w && s == 0)  new_pc = (m_up << 16) | (m_mid << 8) | (d & 'hFE);
    else if (a)            new_pc = (m_pc + 2) & 'h1FFFFF;
    else                   new_pc = m_pc;
    if (r && s == 0) begin
      m_mid = (old_pc >> 8) & 'hFF;
      m_up  = (old_pc >> 16) & 'h1F;
    end else begin
      if (w && s == 1) m_mid = d & 'hFF;
      if (w && s == 2) m_up  = d & 'h1F;
    end
    m_pc = new_pc;
  endtask

  task automatic idle(string req, int s);
    cyc(req, 0, 0, 0, 0, 0, s, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #5;
    chk("R1", "pc in reset", int'(pc), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 1);
    idle("R1", 2);
    // R2: sequential advance
    for (int i = 0; i < 4; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    // R3: latch writes, upper bits zero, window 3 ignored
    cyc("R3", 0, 0, 0, 1, 0, 1, 'h12);
    cyc("R3", 0, 0, 0, 1, 0, 2, 'hFF);
    idle("R3", 2);
    cyc("R3", 0, 0, 0, 1, 0, 3, 'h55);
    idle("R3", 3);
    idle("R3", 1);
    // R4: computed jump, odd byte has bit 0 cleared
    cyc("R4", 0, 0, 0, 1, 0, 0, 'h35);
    idle("R4", 0);
    idle("R8", 0);
    // R5: capture upper bytes into latches
    cyc("R5", 0, 0, 0, 1, 0, 1, 'h00);
    cyc("R5", 0, 0, 0, 1, 0, 2, 'h00);
    cyc("R5", 0, 0, 0, 0, 1, 0, 0);
    idle("R5", 1);
    idle("R5", 2);
    // R8: boundary of implemented memory
    cyc("R8", 0, 0, 0, 1, 0, 1, 'h1F);
    cyc("R8", 0, 0, 0, 1, 0, 2, 'h00);
    cyc("R8", 0, 0, 0, 1, 0, 0, 'hFE);
    cyc("R8", 1, 0, 0, 0, 0, 0, 0);
    idle("R8", 0);
    // R6: vectors, high wins
    cyc("R6", 0, 1, 1, 0, 0, 0, 0);
    cyc("R6", 0, 0, 1, 0, 0, 0, 0);
    idle("R6", 0);
    // R7: interrupt beats write, write beats advance
    cyc("R7", 0, 0, 1, 1, 0, 0, 'h40);
    cyc("R7", 1, 0, 0, 1, 0, 0, 'h40);
    idle("R7", 0);
    // R2: wrap at the top of the space
    cyc("R2", 0, 0, 0, 1, 0, 1, 'hFF);
    cyc("R2", 0, 0, 0, 1, 0, 2, 'h1F);
    cyc("R2", 0, 0, 0, 1, 0, 0, 'hFE);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0);
    idle("R2", 0);
    // mixed traffic
    for (int i = 0; i < 400; i++)
      cyc("R7", ($urandom % 2) == 1, ($urandom % 16) == 0, ($urandom % 12) == 0,
          ($urandom % 4) == 0, ($urandom % 4) == 0, int'($urandom % 4), int'($urandom % 256));
    // R1: asynchronous reset mid-run
    @(negedge clk);
    adv = 0; irq_h = 0; irq_l = 0; we = 0; re = 0;
    #3 rst_n = 1'b0;
    #2;
    chk("R1", "pc async reset", int'(pc), 0);
    m_pc = 0; m_mid = 0; m_up = 0;
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 1);
    idle("R1", 2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule